// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer with a small memory-mapped register port. Firmware programs a timeout length, then turns the timer on. From then on it must write a restart value before the count runs out. Each control register accepts a write only when the write carries that register's own key value. A write with a wrong key is dropped, so software that has gone astray cannot reconfigure or kick the timer by accident.

The count advances on a slow tick strobe, nominally 32 kHz, which arrives already synchronised to the bus clock. When the count runs out, the block either drives a reset pulse of fixed length on its reset pin, with a programmable active level, or raises an interrupt. In dual mode, a second expiry while the interrupt is still pending escalates to a reset. A separate key lets firmware force a reset pulse at once. A read-only status register records whether the last reset came from a timeout or from software.

Top module: `wdt_keyed_top`

## Requirements
- R1: Register byte offsets are: control 0x00, length 0x04, restart 0x08, status 0x0C, software reset 0x14. Reads of the restart register, the software-reset register and any unmapped offset return zero.
- R2: A control write is stored only when bits 31:24 equal 0x22. The stored fields are bit 0 run, bit 1 reset-pin active-low, bit 2 reset-pin drive, bit 3 interrupt mode and bit 6 dual mode. A read returns those bits in place and zero in every other bit.
- R3: A length write is stored only when bits 4:0 equal 0x08. The count is taken from bits 15:5, and a read returns the count in bits 15:5 with zeros elsewhere. After power-on reset the count is 64.
- R4: Writing exactly 0x1971 to the restart register reloads the counter to count×512 ticks. Any other value written there has no effect.
- R5: While the run bit is 0 the counter holds. While it is 1 the counter drops by one on every tick, and it expires on the count×512-th tick after a reload.
- R6: An expiry with interrupt mode off sets off an internal reset pulse of 16 bus-clock cycles, beginning in the cycle after the expiring tick. The counter then reloads.
- R7: The reset pin equals (pulse active AND drive bit) XOR the active-low bit. It therefore idles at the level of the active-low bit.
- R8: Writing exactly 0x1209 to the software-reset register sets off the reset pulse whether or not the run bit is set. Any other value written there has no effect.
- R9: An expiry with interrupt mode on raises the interrupt output and sets off no reset. The interrupt stays high until a valid restart write.
- R10: In interrupt mode with dual mode on, an expiry that finds the interrupt already high also sets off the reset pulse.
- R11: Status bit 0 is set by a timeout-caused reset pulse and bit 1 by a software reset pulse. Both bits survive the generated pulse and clear only on power-on reset. The status register ignores writes.
- R12: After power-on reset the control bits read 0, the status reads 0, and both the reset pin and the interrupt output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low power-on reset |
| tick_i | input | 1 | One-cycle slow tick strobe, synchronous to clk |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 8 | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| wdt_rst_o | output | 1 | Reset pin, active level chosen by the control register |
| wdt_irq_o | output | 1 | Timeout interrupt |

## Verification
The bench sends near-miss keys: off-by-one restart and software-reset values, and a length low field of 0x07 or 0x09. A design that compared too few bits would then reconfigure or kick the timer, and the bench would see the expiry arrive at the wrong tick. It counts the exact tick on which expiry happens, after reloads and after long stretches with the run bit clear. A counter that was off by one, that was reloaded by a bad kick, or that kept running while stopped would move the reset edge. It measures the pulse width under both active levels and with the pin drive off. It also checks that an interrupt-mode expiry leaves the status untouched while a dual-mode second expiry sets it, so a design that mixed up the two paths, or cleared the sticky flags on its own pulse, would read back the wrong status.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_LEN    = 8'h04;
  localparam logic [7:0] OFS_KICK   = 8'h08;
  localparam logic [7:0] OFS_STATUS = 8'h0C;
  localparam logic [7:0] OFS_SWR    = 8'h14;

  localparam logic [7:0]  CTRL_KEY = 8'h22;
  localparam logic [4:0]  LEN_KEY  = 5'h08;
  localparam logic [31:0] KICK_KEY = 32'h0000_1971;
  localparam logic [31:0] SWR_KEY  = 32'h0000_1209;

  localparam int unsigned LEN_LSB = 5;

  typedef struct packed {
    logic dual;
    logic irq_mode;
    logic drive;
    logic act_low;
    logic run;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_word(logic [31:0] w);
    ctrl_t c;
    c.run      = w[0];
    c.act_low  = w[1];
    c.drive    = w[2];
    c.irq_mode = w[3];
    c.dual     = w[6];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_to_word(ctrl_t c);
    logic [31:0] w;
    w    = '0;
    w[0] = c.run;
    w[1] = c.act_low;
    w[2] = c.drive;
    w[3] = c.irq_mode;
    w[6] = c.dual;
    return w;
  endfunction

endpackage

// File: rtl/wdt_keyed_regs.sv
module wdt_keyed_regs
  import wdt_keyed_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned LEN_W   = 11,
  parameter int unsigned LEN_RST = 64
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  input  logic [1:0]        status_i,
  output ctrl_t             ctrl_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              ctrl_we_o,
  output logic              len_we_o,
  output logic              kick_o,
  output logic              swr_o,
  output logic [31:0]       rdata_o
);

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_LEN    = ADDR_W'(OFS_LEN);
  localparam logic [ADDR_W-1:0] A_KICK   = ADDR_W'(OFS_KICK);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_SWR    = ADDR_W'(OFS_SWR);
  localparam int unsigned PAD_W = 32 - LEN_W - LEN_LSB;

  ctrl_t            ctrl_q;
  logic [LEN_W-1:0] len_q;

  assign ctrl_we_o = bus_wr_i && (bus_addr_i == A_CTRL) && (bus_wdata_i[31:24] == CTRL_KEY);
  assign len_we_o  = bus_wr_i && (bus_addr_i == A_LEN)  && (bus_wdata_i[4:0] == LEN_KEY);
  assign kick_o    = bus_wr_i && (bus_addr_i == A_KICK) && (bus_wdata_i == KICK_KEY);
  assign swr_o     = bus_wr_i && (bus_addr_i == A_SWR)  && (bus_wdata_i == SWR_KEY);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      len_q  <= LEN_W'(LEN_RST);
    end else begin
      if (ctrl_we_o) ctrl_q <= ctrl_from_word(bus_wdata_i);
      if (len_we_o)  len_q  <= bus_wdata_i[LEN_LSB +: LEN_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (bus_addr_i)
      A_CTRL:   rdata_o = ctrl_to_word(ctrl_q);
      A_LEN:    rdata_o = {{PAD_W{1'b0}}, len_q, {LEN_LSB{1'b0}}};
      A_STATUS: rdata_o = {30'b0, status_i};
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign len_o  = len_q;

endmodule

// File: rtl/wdt_keyed_count.sv
module wdt_keyed_count #(
  parameter int unsigned LEN_W      = 11,
  parameter int unsigned TICK_SHIFT = 9,
  parameter int unsigned CNT_W      = LEN_W + TICK_SHIFT,
  parameter int unsigned LEN_RST    = 64
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             kick_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);

  function automatic logic [CNT_W-1:0] reload_ticks(logic [LEN_W-1:0] units);
    return {units, {TICK_SHIFT{1'b0}}};
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step     = run_i && tick_i && !kick_i;
  assign expire_o = step && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= reload_ticks(LEN_W'(LEN_RST));
    end else if (kick_i) begin
      cnt_q <= reload_ticks(len_i);
    end else if (expire_o) begin
      cnt_q <= reload_ticks(len_i);
    end else if (step) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/wdt_keyed_action.sv
module wdt_keyed_action
  import wdt_keyed_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 16,
  parameter int unsigned PULSE_W    = $clog2(RST_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       expire_i,
  input  logic       swr_i,
  input  logic       kick_i,
  input  ctrl_t      ctrl_i,
  output logic       trig_timeout_o,
  output logic       pulse_o,
  output logic       irq_o,
  output logic [1:0] status_o
);

  logic [PULSE_W-1:0] pulse_q;
  logic               irq_q;
  logic [1:0]         status_q;
  logic               fire;

  assign trig_timeout_o = expire_i && (!ctrl_i.irq_mode || (ctrl_i.dual && irq_q));
  assign fire           = trig_timeout_o || swr_i;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q  <= '0;
      irq_q    <= 1'b0;
      status_q <= '0;
    end else begin
      if (fire)               pulse_q <= PULSE_W'(RST_CYCLES);
      else if (pulse_q != '0) pulse_q <= pulse_q - PULSE_W'(1);

      if (kick_i)                             irq_q <= 1'b0;
      else if (expire_i && ctrl_i.irq_mode)   irq_q <= 1'b1;

      if (trig_timeout_o) status_q[0] <= 1'b1;
      if (swr_i)          status_q[1] <= 1'b1;
    end
  end

  assign pulse_o  = (pulse_q != '0);
  assign irq_o    = irq_q;
  assign status_o = status_q;

endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top
  import wdt_keyed_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned LEN_W      = 11,
  parameter int unsigned TICK_SHIFT = 9,
  parameter int unsigned RST_CYCLES = 16,
  parameter int unsigned LEN_RST    = 64
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              wdt_rst_o,
  output logic              wdt_irq_o
);

  localparam int unsigned CNT_W = LEN_W + TICK_SHIFT;

  ctrl_t            ctrl;
  logic [LEN_W-1:0] len;
  logic [CNT_W-1:0] cnt;
  logic             ctrl_we, len_we, kick_we, swr_we;
  logic             expire_evt, trig_timeout, pulse_active;
  logic [1:0]       status;

  wdt_keyed_regs #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .LEN_RST(LEN_RST)
  ) u_regs (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .bus_wr_i   (bus_wr_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .status_i   (status),
    .ctrl_o     (ctrl),
    .len_o      (len),
    .ctrl_we_o  (ctrl_we),
    .len_we_o   (len_we),
    .kick_o     (kick_we),
    .swr_o      (swr_we),
    .rdata_o    (bus_rdata_o)
  );

  wdt_keyed_count #(
    .LEN_W     (LEN_W),
    .TICK_SHIFT(TICK_SHIFT),
    .CNT_W     (CNT_W),
    .LEN_RST   (LEN_RST)
  ) u_count (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .run_i   (ctrl.run),
    .kick_i  (kick_we),
    .len_i   (len),
    .cnt_o   (cnt),
    .expire_o(expire_evt)
  );

  wdt_keyed_action #(
    .RST_CYCLES(RST_CYCLES)
  ) u_action (
    .clk           (clk),
    .rst_ni        (rst_ni),
    .expire_i      (expire_evt),
    .swr_i         (swr_we),
    .kick_i        (kick_we),
    .ctrl_i        (ctrl),
    .trig_timeout_o(trig_timeout),
    .pulse_o       (pulse_active),
    .irq_o         (wdt_irq_o),
    .status_o      (status)
  );

  assign wdt_rst_o = (pulse_active & ctrl.drive) ^ ctrl.act_low;

endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
  import wdt_keyed_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LEN_W  = 11,
  parameter int unsigned CNT_W  = 20
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input ctrl_t             ctrl,
  input logic [LEN_W-1:0]  len,
  input logic [CNT_W-1:0]  cnt,
  input logic              kick_we,
  input logic              swr_we,
  input logic              pulse_active,
  input logic              expire_evt,
  input logic              wdt_irq_o,
  input logic [1:0]        status
);

  // R2: control register untouched by a write with the wrong key
  assert_ctrl_key_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == ADDR_W'(OFS_CTRL) && bus_wdata_i[31:24] != CTRL_KEY)
      |=> $stable(ctrl));

  // R3: length register untouched by a write with the wrong low field
  assert_len_key_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == ADDR_W'(OFS_LEN) && bus_wdata_i[4:0] != LEN_KEY)
      |=> $stable(len));

  // R5: a stopped counter holds unless kicked
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (!ctrl.run && !kick_we) |=> $stable(cnt));

  // R8: software reset key always starts the pulse
  assert_swr_pulse_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    swr_we |=> pulse_active);

  // R9: interrupt-mode expiry raises the interrupt
  assert_irq_raise_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (expire_evt && ctrl.irq_mode) |=> wdt_irq_o);

  // R11: status flags are sticky
  assert_status_sticky_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (status[0] |=> status[0]));

  assert_status_sticky_sw_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (status[1] |=> status[1]));

endmodule

bind wdt_keyed_top wdt_keyed_chk #(
  .ADDR_W(ADDR_W),
  .LEN_W (LEN_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_ni      (rst_ni),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .ctrl        (ctrl),
  .len         (len),
  .cnt         (cnt),
  .kick_we     (kick_we),
  .swr_we      (swr_we),
  .pulse_active(pulse_active),
  .expire_evt  (expire_evt),
  .wdt_irq_o   (wdt_irq_o),
  .status      (status)
);

// File: tb/wdt_keyed_top_tb.sv
module wdt_keyed_top_tb;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdt_rst;
  logic        wdt_irq;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  wdt_keyed_top u_dut (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .bus_wr_i   (bus_wr),
    .bus_addr_i (bus_addr),
    .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata),
    .wdt_rst_o  (wdt_rst),
    .wdt_irq_o  (wdt_irq)
  );

  typedef struct packed {
    logic [7:0]  waddr;
    logic [31:0] wdata;
    logic [7:0]  raddr;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    {8'h00, 32'h2200_004A, 8'h00, 32'h0000_004A},
    {8'h00, 32'h2300_000F, 8'h00, 32'h0000_004A},
    {8'h00, 32'h0000_004F, 8'h00, 32'h0000_004A},
    {8'h00, 32'h22FF_FFB4, 8'h00, 32'h0000_0004},
    {8'h04, 32'h0000_0028, 8'h04, 32'h0000_0020},
    {8'h04, 32'h0000_0FE7, 8'h04, 32'h0000_0020},
    {8'h04, 32'h0000_0FE9, 8'h04, 32'h0000_0020},
    {8'h04, 32'hFFFF_0FE8, 8'h04, 32'h0000_0FE0},
    {8'h08, 32'h0000_1971, 8'h08, 32'h0000_0000},
    {8'h14, 32'h0000_0000, 8'h14, 32'h0000_0000},
    {8'h0C, 32'hFFFF_FFFF, 8'h0C, 32'h0000_0000},
    {8'h00, 32'h2200_0000, 8'h00, 32'h0000_0000}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; bus_wr = 1'b0; tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic ticks(int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pulse_width(output int w);
    logic lvl;
    lvl = wdt_rst;
    w = 0;
    while (wdt_rst === lvl && w < 100) begin
      w++;
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int w;

    do_reset();

    // R12 / R3: reset state
    rd(8'h00, r); chk("R12 ctrl after reset", r, 32'h0);
    rd(8'h0C, r); chk("R12 status after reset", r, 32'h0);
    rd(8'h04, r); chk("R3 length after reset", r, 32'h0000_0800);
    chk("R12 reset pin after reset", {31'b0, wdt_rst}, 32'h0);
    chk("R12 irq after reset", {31'b0, wdt_irq}, 32'h0);

    // R1 R2 R3 R4 R8 R11: key and readback table
    for (int i = 0; i < NVEC; i++) begin
      wr(VECS[i].waddr, VECS[i].wdata);
      rd(VECS[i].raddr, r);
      chk($sformatf("R1/R2/R3 vector %0d", i), r, VECS[i].exp);
    end
    rd(8'h20, r); chk("R1 unmapped read", r, 32'h0);
    chk("R8 wrong software key no pulse", {31'b0, wdt_rst}, 32'h0);

    // R5 R6 R11: timeout reset timing
    wr(8'h04, 32'h0000_0028);
    wr(8'h08, 32'h0000_1971);
    wr(8'h00, 32'h2200_0005);
    ticks(511);
    chk("R5 no expiry before 512th tick", {31'b0, wdt_rst}, 32'h0);
    ticks(1);
    chk("R6 reset pin high after expiry", {31'b0, wdt_rst}, 32'h1);
    pulse_width(w);
    chk("R6 pulse width", w, 16);
    rd(8'h0C, r); chk("R11 status timeout flag", r, 32'h1);
    chk("R9 no irq in reset mode", {31'b0, wdt_irq}, 32'h0);

    // R4: restart delays expiry, wrong kick ignored
    wr(8'h08, 32'h0000_1971);
    ticks(300);
    wr(8'h08, 32'h0000_1971);
    ticks(300);
    chk("R4 kicks keep pin low", {31'b0, wdt_rst}, 32'h0);
    wr(8'h08, 32'h0000_1972);
    ticks(211);
    chk("R4 wrong kick: not yet expired", {31'b0, wdt_rst}, 32'h0);
    ticks(1);
    chk("R4 wrong kick did not reload", {31'b0, wdt_rst}, 32'h1);
    pulse_width(w);
    rd(8'h0C, r); chk("R11 status survives pulse", r, 32'h1);

    // R5: stopped counter holds
    do_reset();
    wr(8'h04, 32'h0000_0028);
    wr(8'h08, 32'h0000_1971);
    wr(8'h00, 32'h2200_0004);
    ticks(1000);
    chk("R5 stopped counter no expiry", {31'b0, wdt_rst}, 32'h0);
    wr(8'h00, 32'h2200_0005);
    ticks(511);
    chk("R5 held value then 511 ticks", {31'b0, wdt_rst}, 32'h0);
    ticks(1);
    chk("R5 expiry exactly at 512", {31'b0, wdt_rst}, 32'h1);
    pulse_width(w);

    // R9: interrupt mode
    do_reset();
    wr(8'h04, 32'h0000_0028);
    wr(8'h08, 32'h0000_1971);
    wr(8'h00, 32'h2200_000D);
    ticks(512);
    chk("R9 irq raised", {31'b0, wdt_irq}, 32'h1);
    chk("R9 no reset in irq mode", {31'b0, wdt_rst}, 32'h0);
    rd(8'h0C, r); chk("R11 irq expiry leaves status", r, 32'h0);
    ticks(512);
    chk("R9 irq held, no escalation without dual", {31'b0, wdt_rst}, 32'h0);
    wr(8'h08, 32'h0000_1971);
    chk("R9 restart clears irq", {31'b0, wdt_irq}, 32'h0);

    // R10: dual mode escalation
    wr(8'h00, 32'h2200_004D);
    ticks(512);
    chk("R10 first expiry irq", {31'b0, wdt_irq}, 32'h1);
    chk("R10 first expiry no reset", {31'b0, wdt_rst}, 32'h0);
    ticks(512);
    chk("R10 second expiry resets", {31'b0, wdt_rst}, 32'h1);
    pulse_width(w);
    chk("R10 pulse width", w, 16);
    rd(8'h0C, r); chk("R11 dual escalation sets timeout flag", r, 32'h1);

    // R7 R8 R11: polarity and software reset
    do_reset();
    wr(8'h00, 32'h2200_0006);
    chk("R7 active-low idle high", {31'b0, wdt_rst}, 32'h1);
    wr(8'h14, 32'h0000_1208);
    chk("R8 wrong software key ignored", {31'b0, wdt_rst}, 32'h1);
    rd(8'h0C, r); chk("R8 wrong key leaves status", r, 32'h0);
    wr(8'h14, 32'h0000_1209);
    chk("R8 software reset while stopped", {31'b0, wdt_rst}, 32'h0);
    pulse_width(w);
    chk("R7 active-low pulse width", w, 16);
    rd(8'h0C, r); chk("R11 software flag", r, 32'h2);
    wr(8'h00, 32'h2200_0002);
    wr(8'h14, 32'h0000_1209);
    chk("R7 pin not driven", {31'b0, wdt_rst}, 32'h1);
    repeat (5) @(negedge clk);
    chk("R7 pin not driven later", {31'b0, wdt_rst}, 32'h1);
    do_reset();
    rd(8'h0C, r); chk("R11 power-on reset clears status", r, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule